// File: doc/BRIEF.md
# CAN transceiver channel mode controller

This block is the digital control core of one CAN physical-layer channel. It holds the channel's operating state and decides, cycle by cycle, whether the bus driver may transmit, whether the bus bias and the fast receive comparator are powered, and what the receive output presents to the protocol controller. The inputs are the mode select pin, the transmit data pin, a supply-undervoltage flag, an overtemperature flag, the fast comparator result, the level actually seen on the receive pin, and a wake flag from a separate bus wake-up filter.

There are four states. Unpowered is held while the supply is low. Standby is a low-power listen state. Normal transmits and receives. Silent is a receive-only state that the controller cannot select directly; the block enters it on a fault. There are two faults. Overtemperature stays latched until the transmit pin is high again. A recessive clamp is the case where the comparator sees a dominant bus but the receive pin stays high for a programmable number of cycles; it is released by a dominant receive pin or by leaving for Standby or Unpowered. A low transmit pin always blocks the way into Normal, so a stuck-dominant controller cannot start driving the bus.

Top module: `can_mode_ctrl`

## Requirements
- R1: During reset the mode output is 0 (Unpowered), the driver, bias and comparator enables are low, and the receive output is high.
- R2: When the undervoltage flag is high at a clock edge, the mode becomes 0 (Unpowered) at that edge whatever the other inputs are. In that mode all enables are low and the receive output is high.
- R3: When undervoltage is low and the mode select input is high at an edge, the mode becomes 1 (Standby). The driver, bias and comparator enables are low, and the receive output is the inverse of the wake flag.
- R4: From Standby or Unpowered, with the mode select low and undervoltage low, the block leaves for Normal or Silent only if the transmit input is high. With the transmit input low it stays in its current mode.
- R5: In mode 3 (Normal) the driver, bias and comparator enables are all high, and the receive output is the inverse of the comparator input (comparator 1 means dominant).
- R6: An overtemperature flag seen in Normal moves the block to mode 2 (Silent) at that edge: driver low, bias and comparator high, receive output the inverse of the comparator. The block returns to Normal only at an edge where the overtemperature flag is low and the transmit input is high. An entry from Standby with overtemperature present goes to Silent.
- R7: In Normal, a comparator input of 1 together with a receive pin of 1 on CLAMP_CYC consecutive edges sets the clamp fault, and the block is in Silent one edge later. A shorter run, broken by either condition, leaves the block in Normal.
- R8: A clamp fault is released by a low receive pin; the block then returns to Normal at that edge if the transmit input is high. A move to Standby or Unpowered also clears the clamp fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stby_i | input | 1 | Mode select pin, 1 selects Standby |
| txd_i | input | 1 | Transmit data pin, 0 = dominant |
| uv_i | input | 1 | Supply undervoltage flag |
| ot_i | input | 1 | Overtemperature flag |
| hsc_dom_i | input | 1 | Fast comparator result, 1 = dominant |
| rxd_pin_i | input | 1 | Level observed on the receive pin |
| wake_i | input | 1 | Wake flag from the wake-up filter |
| mode_o | output | 2 | 0 Unpowered, 1 Standby, 2 Silent, 3 Normal |
| drv_en_o | output | 1 | Bus driver enable |
| bias_en_o | output | 1 | Bus bias enable |
| hsc_en_o | output | 1 | Fast comparator enable |
| rxd_o | output | 1 | Receive data to the protocol controller |

## Verification
The assertions check on every cycle that undervoltage and the mode select input force their states on the next edge, that the driver never comes on unless the transmit input was high, that overtemperature in Normal always ends in Silent, and that a Silent-to-Normal return never happens while overtemperature is present. The clamp debounce length, the release of the clamp fault by a dominant receive pin or by Standby, the overtemperature hold while the transmit input stays low, and the receive-output selection in each mode depend on multi-cycle histories, so only the bench's scenarios show them. An exhaustive sweep of all input combinations from Standby and from Normal also covers the decision priorities.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  typedef enum logic [1:0] {
    MODE_UNPWR  = 2'd0,
    MODE_STBY   = 2'd1,
    MODE_SILENT = 2'd2,
    MODE_NORMAL = 2'd3
  } mode_e;
endpackage

// File: rtl/can_clamp_det.sv
module can_clamp_det #(
  parameter int CLAMP_CYC = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic hsc_dom_i,
  input  logic rxd_pin_i,
  input  logic rel_i,
  output logic flag_o
);
  localparam int CNT_W = $clog2(CLAMP_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLAMP_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             cond;

  // comparator dominant but the receive pin still high
  assign cond = arm_i & hsc_dom_i & rxd_pin_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (!cond)              cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
      if (!rxd_pin_i || rel_i)            flag_q <= 1'b0;
      else if (cond && cnt_q == LAST)     flag_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/can_ot_hold.sv
module can_ot_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ot_i,
  input  logic txd_i,
  output logic err_o
);
  logic ot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ot_q <= 1'b0;
    else if (ot_i)  ot_q <= 1'b1;
    else if (txd_i) ot_q <= 1'b0;
  end

  // held until the flag is gone and txd is recessive
  assign err_o = ot_i | (ot_q & ~txd_i);
endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  stby_i,
  input  logic  txd_i,
  input  logic  uv_i,
  input  logic  err_i,
  output mode_e mode_o
);
  mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (uv_i)        mode_d = MODE_UNPWR;
    else if (stby_i) mode_d = MODE_STBY;
    else begin
      unique case (mode_q)
        MODE_UNPWR, MODE_STBY:
          if (txd_i) mode_d = err_i ? MODE_SILENT : MODE_NORMAL;
        MODE_NORMAL:
          if (err_i) mode_d = MODE_SILENT;
        MODE_SILENT:
          if (!err_i && txd_i) mode_d = MODE_NORMAL;
        default: mode_d = MODE_UNPWR;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_UNPWR;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
#(
  parameter int CLAMP_CYC = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stby_i,
  input  logic       txd_i,
  input  logic       uv_i,
  input  logic       ot_i,
  input  logic       hsc_dom_i,
  input  logic       rxd_pin_i,
  input  logic       wake_i,
  output logic [1:0] mode_o,
  output logic       drv_en_o,
  output logic       bias_en_o,
  output logic       hsc_en_o,
  output logic       rxd_o
);
  mode_e mode;
  logic  ot_err, clamp_flag, err;

  can_ot_hold i_ot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ot_i   (ot_i),
    .txd_i  (txd_i),
    .err_o  (ot_err)
  );

  can_clamp_det #(.CLAMP_CYC(CLAMP_CYC)) i_clamp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (mode == MODE_NORMAL),
    .hsc_dom_i (hsc_dom_i),
    .rxd_pin_i (rxd_pin_i),
    .rel_i     (stby_i | uv_i),
    .flag_o    (clamp_flag)
  );

  // a dominant receive pin releases the clamp fault at once
  assign err = ot_err | (clamp_flag & rxd_pin_i);

  can_mode_fsm i_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stby_i (stby_i),
    .txd_i  (txd_i),
    .uv_i   (uv_i),
    .err_i  (err),
    .mode_o (mode)
  );

  assign mode_o    = mode;
  assign drv_en_o  = (mode == MODE_NORMAL);
  assign bias_en_o = (mode == MODE_NORMAL) || (mode == MODE_SILENT);
  assign hsc_en_o  = bias_en_o;

  always_comb begin
    unique case (mode)
      MODE_UNPWR: rxd_o = 1'b1;
      MODE_STBY:  rxd_o = ~wake_i;
      default:    rxd_o = ~hsc_dom_i;
    endcase
  end
endmodule

// File: rtl/can_mode_ctrl_chk.sv
module can_mode_ctrl_chk
  import can_mode_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       stby_i,
  input logic       txd_i,
  input logic       uv_i,
  input logic       ot_i,
  input logic [1:0] mode_o,
  input logic       drv_en_o
);
  p_uv_unpwr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |=> (mode_o == MODE_UNPWR) && !drv_en_o);

  p_stby_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!uv_i && stby_i) |=> mode_o == MODE_STBY);

  p_drv_needs_txd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_en_o) |-> $past(txd_i));

  p_ot_to_silent_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_NORMAL && !uv_i && !stby_i && ot_i) |=> mode_o == MODE_SILENT);

  p_silent_exit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == MODE_SILENT && mode_o == MODE_NORMAL) |-> $past(!ot_i && txd_i));
endmodule

bind can_mode_ctrl can_mode_ctrl_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .stby_i   (stby_i),
  .txd_i    (txd_i),
  .uv_i     (uv_i),
  .ot_i     (ot_i),
  .mode_o   (mode_o),
  .drv_en_o (drv_en_o)
);

// File: tb/test_can_mode_ctrl.sv
module test_can_mode_ctrl;
  localparam int N = 9;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic stby_i = 1'b1, txd_i = 1'b1, uv_i = 1'b0, ot_i = 1'b0;
  logic hsc_dom_i = 1'b0, rxd_pin_i = 1'b1, wake_i = 1'b0;
  logic [1:0] mode_o;
  logic drv_en_o, bias_en_o, hsc_en_o, rxd_o;

  int checks = 0, fails = 0, cyc = 0;

  always #5 clk_i = ~clk_i;

  can_mode_ctrl #(.CLAMP_CYC(N)) i_can_mode_ctrl (.*);

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 100000);
      summary();
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic set_in(logic s, logic t, logic u, logic o, logic h, logic r, logic w);
    stby_i = s; txd_i = t; uv_i = u; ot_i = o; hsc_dom_i = h; rxd_pin_i = r; wake_i = w;
  endtask

  // outputs implied by the mode code (R2, R3, R5, R6)
  task automatic check_outs(string req, int m);
    check(req, "mode", int'(mode_o), m);
    check(req, "drv_en", int'(drv_en_o), (m == 3) ? 1 : 0);
    check(req, "bias_en", int'(bias_en_o), (m >= 2) ? 1 : 0);
    check(req, "hsc_en", int'(hsc_en_o), (m >= 2) ? 1 : 0);
    check(req, "rxd", int'(rxd_o), (m == 0) ? 1 : (m == 1) ? int'(!wake_i) : int'(!hsc_dom_i));
  endtask

  function automatic string tag(logic u, logic s, logic t, logic o);
    if (u) return "R2";
    if (s) return "R3";
    if (o) return "R6";
    if (!t) return "R4";
    return "R5";
  endfunction

  initial begin
    step(2);
    check_outs("R1", 0);
    rst_ni = 1'b1;
    step(1);

    // sweep from Standby
    for (int v = 0; v < 128; v++) begin
      set_in(1, 1, 0, 0, 0, 1, 0);
      step(1);
      set_in(v[6], v[5], v[4], v[3], v[2], v[1], v[0]);
      step(1);
      check_outs(tag(v[4], v[6], v[5], v[3]),
                 v[4] ? 0 : v[6] ? 1 : !v[5] ? 1 : v[3] ? 2 : 3);
    end

    // sweep from Normal
    for (int v = 0; v < 128; v++) begin
      set_in(1, 1, 0, 0, 0, 1, 0);
      step(1);
      set_in(0, 1, 0, 0, 0, 1, 0);
      step(1);
      set_in(v[6], v[5], v[4], v[3], v[2], v[1], v[0]);
      step(1);
      check_outs(tag(v[4], v[6], 1'b1, v[3]),
                 v[4] ? 0 : v[6] ? 1 : v[3] ? 2 : 3);
    end

    // R4: leaving Unpowered waits for txd high
    set_in(0, 1, 1, 0, 0, 1, 0); step(1);
    set_in(0, 0, 0, 0, 0, 1, 0); step(3);
    check("R4", "stay unpowered txd low", int'(mode_o), 0);
    txd_i = 1'b1; step(1);
    check("R4", "enter normal txd high", int'(mode_o), 3);

    // R6: overtemperature held while txd low
    ot_i = 1'b1; step(1);
    check("R6", "silent on ot", int'(mode_o), 2);
    set_in(0, 0, 0, 0, 0, 1, 0); step(3);
    check("R6", "held while txd low", int'(mode_o), 2);
    check("R6", "drv off", int'(drv_en_o), 0);
    txd_i = 1'b1; step(1);
    check("R6", "back to normal", int'(mode_o), 3);

    // R7: short runs ignored
    hsc_dom_i = 1'b1; step(N - 1);
    hsc_dom_i = 1'b0; step(1);
    hsc_dom_i = 1'b1; step(N - 1);
    rxd_pin_i = 1'b0; step(1);
    rxd_pin_i = 1'b1; step(N - 1);
    check("R7", "short run stays normal", int'(mode_o), 3);
    hsc_dom_i = 1'b0; step(2);
    // R7: full run
    hsc_dom_i = 1'b1; step(N);
    check("R7", "normal at debounce edge", int'(mode_o), 3);
    step(1);
    check("R7", "silent after clamp", int'(mode_o), 2);
    step(3);
    check("R7", "clamp persists", int'(mode_o), 2);
    // R8: released by dominant receive pin
    rxd_pin_i = 1'b0; step(1);
    check("R8", "release by rxd low", int'(mode_o), 3);
    rxd_pin_i = 1'b1; hsc_dom_i = 1'b0; step(2);
    check("R8", "stays normal after release", int'(mode_o), 3);

    // R8: released by Standby
    hsc_dom_i = 1'b1; step(N + 1);
    check("R8", "clamped again", int'(mode_o), 2);
    stby_i = 1'b1; step(1);
    check("R8", "standby", int'(mode_o), 1);
    set_in(0, 1, 0, 0, 0, 1, 0); step(1);
    check("R8", "normal after standby clears clamp", int'(mode_o), 3);

    summary();
  end
endmodule